// File: doc/BRIEF.md
# Receive Frame Scatter Engine

This block takes a received frame, already accepted by an address filter, as a byte stream and places it in host memory. The bytes are collected in an internal staging store while the Ethernet CRC-32 is accumulated. When the end-of-frame strobe arrives, the engine walks a chain of descriptors in memory. The current frame descriptor pointer is read from a control block whose base address is an input. From that descriptor the engine reaches a linked list of buffer descriptors. It scatters the padded frame and its trailing CRC across those buffers, one buffer after another.

After the last byte is placed, the engine writes each buffer's byte count with its flags. It passes the first unused buffer descriptor on to the following frame descriptor and writes the completion status of the frame descriptor. It then pulses its interrupt. A suspend request carried in the frame descriptor parks the receive unit, and further frames are discarded until software resumes it. All memory traffic goes through one request/ready port that carries 16-bit big-endian words and single bytes. A 32-bit pointer is two words, with the low half at the lower address.

Top module: `rx_scatter`

## Requirements
- R1: A frame is stored only if its first byte arrives while the receive unit is not suspended and no earlier frame is still being placed. A frame that fails this test is discarded whole and causes no memory request. `mem_req` is never high while `busy` is low.
- R2: On the end-of-frame strobe, the engine reads the frame descriptor pointer from `scb_base`+8 (low word) and +10 (high word). From the frame descriptor it reads the command word at +2, the next-frame link at +4/+6 and the first buffer descriptor pointer at +8/+10.
- R3: A frame shorter than 60 bytes is extended with zero bytes to 60. The placed length is the padded length plus 4 CRC bytes.
- R4: The CRC is computed over the unpadded bytes only. It uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. The resulting 32-bit value is placed bits 31:24 first.
- R5: Each buffer descriptor holds its count word at +0, its next-descriptor link at +4/+6, its buffer address at +8/+10 and its size word at +12. Size bits 13:0 give the capacity and bit 15 marks the last buffer. Each buffer takes min(capacity, remaining) consecutive bytes of the data-then-CRC stream, so the CRC may straddle two buffers and a capacity of zero takes no byte.
- R6: After filling a buffer, the engine writes its count word as the byte count in bits 13:0 with bit 14 set. Bit 15 is also set on the buffer that receives the final byte.
- R7: The engine writes the link of the last buffer it used into +8/+10 of the next frame descriptor.
- R8: The frame descriptor status at +0 is written as 0xA000 ORed with `rx_group` (bit 0) of the frame.
- R9: Completion raises `irq` for exactly one cycle. The engine is idle in the following cycle.
- R10: If command bit 14 is set, completion also pulses `rnr_set` and `ru_suspended` goes high. It stays high, and frames are discarded, until a `ru_resume` pulse clears it.
- R11: If a buffer marked last is filled while bytes remain, placement stops. `overrun` pulses with `irq`, the hand-off is still written, and the status is 0x8000 ORed with the group bit (bit 13 clear).
- R12: A memory request held without `mem_ready` keeps its address, direction and write data unchanged.
- R13: During reset `busy`, `irq`, `mem_req` and `ru_suspended` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scb_base | input | 32 | Byte address of the control block |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_group | input | 1 | Broadcast/multicast flag, taken with the final byte |
| ru_resume | input | 1 | Clears the suspended state |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_byte | output | 1 | 1 byte write (data in bits 7:0), 0 word access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| busy | output | 1 | Descriptor walk in progress |
| ru_suspended | output | 1 | Receive unit suspended |
| irq | output | 1 | Frame-received pulse |
| rnr_set | output | 1 | Receive unit left the active state (pulse) |
| overrun | output | 1 | Buffer chain ran out (pulse) |

## Verification
A stuck or miscounted fill counter shows at the ports within one buffer. The count word written back, or the byte just past the used region, differs from the stream position that the bench predicts. A wrong position in the data-then-pad-then-CRC sequence corrupts the CRC bytes, which are checked wherever the buffer boundaries split them. A suspended or busy state that leaks appears as a memory request or interrupt during a frame that should have been discarded. A hand-off register that is not updated appears in the next frame descriptor as soon as the frame completes.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 14;

    localparam logic [ADDR_W-1:0] OFS_CB_FRAME  = 32'd8;
    localparam logic [ADDR_W-1:0] OFS_FD_CMD    = 32'd2;
    localparam logic [ADDR_W-1:0] OFS_LINK      = 32'd4;
    localparam logic [ADDR_W-1:0] OFS_FD_CHAIN  = 32'd8;
    localparam logic [ADDR_W-1:0] OFS_BD_BUF    = 32'd8;
    localparam logic [ADDR_W-1:0] OFS_BD_SIZE   = 32'd12;
    localparam logic [ADDR_W-1:0] OFS_HI        = 32'd2;

    localparam int BIT_DONE  = 15;
    localparam int BIT_FILL  = 14;
    localparam int BIT_GOOD  = 13;
    localparam int BIT_PARK  = 14;
    localparam int BIT_FINAL = 15;

    typedef enum logic [4:0] {
        W_IDLE, W_FP_LO, W_FP_HI, W_CMD, W_NX_LO, W_NX_HI, W_CH_LO, W_CH_HI,
        W_SIZE, W_BA_LO, W_BA_HI, W_LK_LO, W_LK_HI, W_DATA, W_COUNT,
        W_HO_LO, W_HO_HI, W_STAT, W_DONE
    } walk_st_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rxs_stage.sv
module rxs_stage
    import rxs_pkg::*;
#(
    parameter int MAX_FRAME = 1536,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_flag,
    input  logic             accept_en,
    input  logic             release_i,
    input  logic [LEN_W-1:0] rd_pos,
    output logic             full_o,
    output logic [LEN_W-1:0] len_o,
    output logic [31:0]      crc_o,
    output logic             flag_o,
    output logic [7:0]       rd_byte_o
);
    typedef struct packed {
        logic             mid;
        logic             skip;
        logic             full;
        logic [LEN_W-1:0] len;
        logic [31:0]      crc;
        logic             flag;
    } stage_t;

    stage_t q, d;
    logic [7:0]       store [MAX_FRAME];
    logic             wr_en;
    logic [LEN_W-1:0] wr_idx;
    logic [LEN_W-1:0] base_len;
    logic [31:0]      base_crc;
    logic             starting, capture;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        starting = !q.mid && !q.skip;
        capture  = q.mid || (starting && accept_en && !q.full);
        base_len = starting ? '0 : q.len;
        base_crc = starting ? 32'hFFFF_FFFF : q.crc;
        wr_idx   = base_len;
        if (release_i) d.full = 1'b0;
        if (in_valid) begin
            if (capture) begin
                d.len = base_len;
                d.crc = base_crc;
                if (base_len < LEN_W'(MAX_FRAME)) begin
                    wr_en = 1'b1;
                    d.len = base_len + 1'b1;
                    d.crc = crc_step(base_crc, in_data);
                end
            end
            if (in_last) begin
                d.mid  = 1'b0;
                d.skip = 1'b0;
                if (capture) begin
                    d.full = 1'b1;
                    d.flag = in_flag;
                end
            end else begin
                d.mid  = capture;
                d.skip = !capture;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= in_data;
    end

    assign full_o    = q.full;
    assign len_o     = q.len;
    assign crc_o     = ~q.crc;
    assign flag_o    = q.flag;
    assign rd_byte_o = (rd_pos < LEN_W'(MAX_FRAME)) ? store[rd_pos] : 8'h00;
endmodule

// File: rtl/rxs_walk.sv
module rxs_walk
    import rxs_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] scb_base,
    input  logic              frame_full,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [31:0]       frame_crc,
    input  logic              frame_flag,
    output logic [LEN_W-1:0]  rd_pos,
    input  logic [7:0]        rd_byte,
    output logic              release_o,
    input  logic              resume_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy_o,
    output logic              suspended_o,
    output logic              done_o,
    output logic              rnr_o,
    output logic              ovr_o
);
    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] fd;
        logic [ADDR_W-1:0] nfd;
        logic [ADDR_W-1:0] bd;
        logic [ADDR_W-1:0] lnk;
        logic [ADDR_W-1:0] ba;
        logic              park;
        logic              last_bd;
        logic [CNT_W-1:0]  cap;
        logic [LEN_W-1:0]  pos;
        logic [LEN_W-1:0]  total;
        logic [CNT_W-1:0]  num;
        logic [CNT_W-1:0]  cnt;
        logic              ovr;
        logic              susp;
    } walk_t;

    walk_t q, d;
    logic             ack;
    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] padded;
    logic [7:0]       out_byte;
    logic [CNT_W-1:0] fit;

    always_comb begin
        remain = q.total - q.pos;
        padded = (frame_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frame_len;
        fit    = (CNT_W'(remain) < q.cap) ? CNT_W'(remain) : q.cap;
        if (q.pos < frame_len)            out_byte = rd_byte;
        else if (remain > LEN_W'(4))      out_byte = 8'h00;
        else begin
            case (remain[2:0])
                3'd4:    out_byte = frame_crc[31:24];
                3'd3:    out_byte = frame_crc[23:16];
                3'd2:    out_byte = frame_crc[15:8];
                default: out_byte = frame_crc[7:0];
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            W_FP_LO: begin mem_req = 1'b1; mem_addr = scb_base + OFS_CB_FRAME; end
            W_FP_HI: begin mem_req = 1'b1; mem_addr = scb_base + OFS_CB_FRAME + OFS_HI; end
            W_CMD:   begin mem_req = 1'b1; mem_addr = q.fd + OFS_FD_CMD; end
            W_NX_LO: begin mem_req = 1'b1; mem_addr = q.fd + OFS_LINK; end
            W_NX_HI: begin mem_req = 1'b1; mem_addr = q.fd + OFS_LINK + OFS_HI; end
            W_CH_LO: begin mem_req = 1'b1; mem_addr = q.fd + OFS_FD_CHAIN; end
            W_CH_HI: begin mem_req = 1'b1; mem_addr = q.fd + OFS_FD_CHAIN + OFS_HI; end
            W_SIZE:  begin mem_req = 1'b1; mem_addr = q.bd + OFS_BD_SIZE; end
            W_BA_LO: begin mem_req = 1'b1; mem_addr = q.bd + OFS_BD_BUF; end
            W_BA_HI: begin mem_req = 1'b1; mem_addr = q.bd + OFS_BD_BUF + OFS_HI; end
            W_LK_LO: begin mem_req = 1'b1; mem_addr = q.bd + OFS_LINK; end
            W_LK_HI: begin mem_req = 1'b1; mem_addr = q.bd + OFS_LINK + OFS_HI; end
            W_DATA: begin
                mem_req   = (q.cnt != q.num);
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = q.ba + ADDR_W'(q.cnt);
                mem_wdata = {8'h00, out_byte};
            end
            W_COUNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.bd;
                mem_wdata = {(q.pos == q.total), 1'b1, q.num};
            end
            W_HO_LO: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = q.nfd + OFS_FD_CHAIN; mem_wdata = q.bd[15:0];
            end
            W_HO_HI: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = q.nfd + OFS_FD_CHAIN + OFS_HI; mem_wdata = q.bd[31:16];
            end
            W_STAT: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = q.fd;
                mem_wdata = '0;
                mem_wdata[BIT_DONE] = 1'b1;
                mem_wdata[BIT_GOOD] = !q.ovr;
                mem_wdata[0]        = frame_flag;
            end
            default: ;
        endcase
    end

    assign ack = mem_req && mem_ready;

    always_comb begin
        d = q;
        if (resume_i) d.susp = 1'b0;
        case (q.st)
            W_IDLE: if (frame_full) begin
                d.pos   = '0;
                d.total = padded + LEN_W'(4);
                d.ovr   = 1'b0;
                d.st    = W_FP_LO;
            end
            W_FP_LO: if (ack) begin d.fd[15:0]  = mem_rdata; d.st = W_FP_HI; end
            W_FP_HI: if (ack) begin d.fd[31:16] = mem_rdata; d.st = W_CMD; end
            W_CMD:   if (ack) begin d.park = mem_rdata[BIT_PARK]; d.st = W_NX_LO; end
            W_NX_LO: if (ack) begin d.nfd[15:0]  = mem_rdata; d.st = W_NX_HI; end
            W_NX_HI: if (ack) begin d.nfd[31:16] = mem_rdata; d.st = W_CH_LO; end
            W_CH_LO: if (ack) begin d.bd[15:0]  = mem_rdata; d.st = W_CH_HI; end
            W_CH_HI: if (ack) begin d.bd[31:16] = mem_rdata; d.st = W_SIZE; end
            W_SIZE: if (ack) begin
                d.cap     = mem_rdata[CNT_W-1:0];
                d.last_bd = mem_rdata[BIT_FINAL];
                d.st      = W_BA_LO;
            end
            W_BA_LO: if (ack) begin d.ba[15:0]  = mem_rdata; d.st = W_BA_HI; end
            W_BA_HI: if (ack) begin d.ba[31:16] = mem_rdata; d.st = W_LK_LO; end
            W_LK_LO: if (ack) begin d.lnk[15:0] = mem_rdata; d.st = W_LK_HI; end
            W_LK_HI: if (ack) begin
                d.lnk[31:16] = mem_rdata;
                d.num        = fit;
                d.cnt        = '0;
                d.st         = W_DATA;
            end
            W_DATA: begin
                if (q.cnt == q.num) d.st = W_COUNT;
                else if (ack) begin
                    d.cnt = q.cnt + 1'b1;
                    d.pos = q.pos + 1'b1;
                end
            end
            W_COUNT: if (ack) begin
                d.bd = q.lnk;
                if (q.pos == q.total) d.st = W_HO_LO;
                else if (q.last_bd) begin
                    d.ovr = 1'b1;
                    d.st  = W_HO_LO;
                end else d.st = W_SIZE;
            end
            W_HO_LO: if (ack) d.st = W_HO_HI;
            W_HO_HI: if (ack) d.st = W_STAT;
            W_STAT:  if (ack) d.st = W_DONE;
            W_DONE: begin
                if (q.park) d.susp = 1'b1;
                d.st = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: W_IDLE, default: '0};
        else        q <= d;
    end

    assign rd_pos      = q.pos;
    assign release_o   = (q.st == W_DONE);
    assign busy_o      = (q.st != W_IDLE);
    assign suspended_o = q.susp;
    assign done_o      = (q.st == W_DONE);
    assign rnr_o       = (q.st == W_DONE) && q.park;
    assign ovr_o       = (q.st == W_DONE) && q.ovr;
endmodule

// File: rtl/rx_scatter.sv
module rx_scatter
    import rxs_pkg::*;
#(
    parameter int MAX_FRAME = 1536,
    parameter int MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] scb_base,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_group,
    input  logic              ru_resume,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              ru_suspended,
    output logic              irq,
    output logic              rnr_set,
    output logic              overrun
);
    localparam int LEN_W = $clog2(MAX_FRAME + 5);

    logic             full, flag, release_s;
    logic [LEN_W-1:0] flen, pos;
    logic [31:0]      crc;
    logic [7:0]       rbyte;

    rxs_stage #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_flag(rx_group),
        .accept_en(!ru_suspended), .release_i(release_s), .rd_pos(pos),
        .full_o(full), .len_o(flen), .crc_o(crc), .flag_o(flag), .rd_byte_o(rbyte)
    );

    rxs_walk #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_walk (
        .clk(clk), .rst_n(rst_n), .scb_base(scb_base),
        .frame_full(full), .frame_len(flen), .frame_crc(crc), .frame_flag(flag),
        .rd_pos(pos), .rd_byte(rbyte), .release_o(release_s), .resume_i(ru_resume),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy_o(busy), .suspended_o(ru_suspended), .done_o(irq),
        .rnr_o(rnr_set), .ovr_o(overrun)
    );
endmodule

// File: rtl/rx_scatter_chk.sv
module rx_scatter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ready,
    input logic        busy,
    input logic        ru_suspended,
    input logic        irq,
    input logic        rnr_set,
    input logic        overrun
);
    // R12: a stalled request keeps its address, direction and data
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R1: no memory traffic outside a descriptor walk
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: completion is a single-cycle pulse, followed by idle
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq && !busy);

    // R10: park request leads to the suspended state
    p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rnr_set |=> ru_suspended);

    // R10: park indication comes only with completion
    p_park_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rnr_set |-> irq);

    // R11: overrun is reported only with completion
    p_ovr_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> irq);
endmodule

bind rx_scatter rx_scatter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .busy(busy), .ru_suspended(ru_suspended), .irq(irq),
    .rnr_set(rnr_set), .overrun(overrun)
);

// File: tb/rx_scatter_bench.sv
module rx_scatter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] scb_base;
    logic        rx_valid, rx_last, rx_group, ru_resume;
    logic [7:0]  rx_data;
    logic        mem_req, mem_we, mem_byte, mem_ready;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, ru_suspended, irq, rnr_set, overrun;

    always #5 clk = ~clk;

    rx_scatter u_rx_scatter (
        .clk(clk), .rst_n(rst_n), .scb_base(scb_base), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_group(rx_group), .ru_resume(ru_resume),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .ru_suspended(ru_suspended), .irq(irq), .rnr_set(rnr_set),
        .overrun(overrun)
    );

    // memory model: byte array, big-endian words
    logic [7:0] mem [0:8191];
    logic       stall;
    int         cyc = 0;
    assign mem_rdata = {mem[mem_addr[12:0]], mem[mem_addr[12:0] + 13'd1]};
    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) begin
            if (mem_byte) mem[mem_addr[12:0]] <= mem_wdata[7:0];
            else begin
                mem[mem_addr[12:0]]         <= mem_wdata[15:8];
                mem[mem_addr[12:0] + 13'd1] <= mem_wdata[7:0];
            end
        end
    end
    always @(negedge clk) begin
        cyc++;
        mem_ready <= stall ? (cyc[0] ^ cyc[2]) : 1'b1;
    end

    int irq_cnt = 0, rnr_cnt = 0, ovr_cnt = 0, req_cnt = 0;
    always @(negedge clk) begin
        if (irq)     irq_cnt++;
        if (rnr_set) rnr_cnt++;
        if (overrun) ovr_cnt++;
        if (mem_req) req_cnt++;
    end

    int n_tests = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    localparam logic [15:0] FD0 = 16'h0200, FD1 = 16'h0300, BD0 = 16'h0400;

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] bench_crc(input int seed, input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, pat(seed, i)};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic wr16(input int a, input logic [15:0] v);
        mem[a] = v[15:8]; mem[a+1] = v[7:0];
    endtask
    function automatic logic [15:0] rd16(input int a);
        return {mem[a], mem[a+1]};
    endfunction

    int caps [4];
    logic [3:0] lastm;

    task automatic setup(input logic [15:0] cmd);
        wr16(32'h0108, FD0); wr16(32'h010A, 16'h0);
        wr16(FD0, 16'h0); wr16(FD0 + 2, cmd);
        wr16(FD0 + 4, FD1); wr16(FD0 + 6, 16'h0);
        wr16(FD0 + 8, BD0); wr16(FD0 + 10, 16'h0);
        wr16(FD1 + 8, 16'h0); wr16(FD1 + 10, 16'h0);
        for (int b = 0; b < 4; b++) begin
            int bd = BD0 + 16 * b;
            wr16(bd, 16'h0);
            wr16(bd + 4, 16'(bd + 16)); wr16(bd + 6, 16'h0);
            wr16(bd + 8, 16'(32'h1000 + 32'h400 * b)); wr16(bd + 10, 16'h0);
            wr16(bd + 12, {lastm[b], 1'b0, 14'(caps[b])});
            for (int i = 0; i < 32'h400; i++) mem[32'h1000 + 32'h400 * b + i] = 8'hEE;
        end
    endtask

    task automatic send(input int seed, input int len, input logic grp);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, i);
            rx_last = (i == len - 1); rx_group = grp;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_done(input int base);
        int t = 0;
        while (irq_cnt == base && t < 20000) begin @(negedge clk); t++; end
        @(negedge clk);
        chk(irq_cnt == base + 1, "R9", "completion irq", irq_cnt - base, 1);
    endtask

    // expected placement computed from the requirements
    task automatic check_frame(input int seed, input int len, input logic grp,
                               input int ovr0, input int rnr0, input bit park);
        int plen = (len < 60) ? 60 : len;
        int total = plen + 4;
        logic [31:0] crc = bench_crc(seed, len);
        int pos = 0, lastb = 0;
        bit ovr = 0;
        for (int b = 0; b < 4; b++) begin
            int base = 32'h1000 + 32'h400 * b;
            int num = (caps[b] < total - pos) ? caps[b] : total - pos;
            int bad = 0;
            logic [15:0] expc;
            for (int i = 0; i < num; i++) begin
                int p = pos + i;
                logic [7:0] e;
                if (p < len) e = pat(seed, p);
                else if (p < plen) e = 8'h00;           // R3 padding
                else e = crc[31 - 8 * (p - plen) -: 8];  // R4 CRC high byte first
                if (mem[base + i] != e) bad++;
            end
            chk(bad == 0, "R5", $sformatf("buffer %0d bytes (R3/R4)", b), bad, 0);
            chk(mem[base + num] == 8'hEE, "R5", "byte past fill untouched", mem[base + num], 8'hEE);
            pos += num;
            expc = {(pos == total), 1'b1, 14'(num)};
            chk(rd16(BD0 + 16 * b) == expc, "R6", $sformatf("count word %0d", b), rd16(BD0 + 16 * b), expc);
            lastb = b;
            if (pos == total) break;
            if (lastm[b]) begin ovr = 1; break; end
        end
        chk(rd16(FD1 + 8) == 16'(BD0 + 16 * (lastb + 1)) && rd16(FD1 + 10) == 16'h0, "R7",
            "hand-off pointer", rd16(FD1 + 8), BD0 + 16 * (lastb + 1));
        chk(rd16(FD0) == (ovr ? 16'h8000 : 16'hA000) | {15'h0, grp}, ovr ? "R11" : "R8",
            "frame status", rd16(FD0), (ovr ? 16'h8000 : 16'hA000) | {15'h0, grp});
        chk((ovr_cnt - ovr0) == int'(ovr), "R11", "overrun pulses", ovr_cnt - ovr0, int'(ovr));
        chk((rnr_cnt - rnr0) == int'(park), "R10", "rnr pulses", rnr_cnt - rnr0, int'(park));
    endtask

    typedef struct packed {
        logic [10:0] len;
        logic [7:0]  seed;
        logic [9:0]  c0, c1, c2, c3;
        logic [3:0]  last;
        logic        grp;
        logic        stl;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{11'd100, 8'd1, 10'd200, 10'd0,   10'd0,   10'd0,   4'b1000, 1'b0, 1'b0},
        '{11'd20,  8'd2, 10'd64,  10'd10,  10'd10,  10'd10,  4'b1000, 1'b0, 1'b1},
        '{11'd60,  8'd3, 10'd30,  10'd30,  10'd30,  10'd30,  4'b1000, 1'b0, 1'b0},
        '{11'd70,  8'd4, 10'd72,  10'd10,  10'd10,  10'd10,  4'b1000, 1'b0, 1'b1},
        '{11'd150, 8'd5, 10'd50,  10'd50,  10'd50,  10'd50,  4'b0010, 1'b0, 1'b0},
        '{11'd61,  8'd6, 10'd0,   10'd80,  10'd10,  10'd10,  4'b1000, 1'b1, 1'b1},
        '{11'd62,  8'd7, 10'd63,  10'd10,  10'd10,  10'd10,  4'b1000, 1'b0, 1'b0},
        '{11'd200, 8'd8, 10'd100, 10'd100, 10'd100, 10'd100, 4'b1000, 1'b1, 1'b1}
    };

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        int b0, o0, r0, q0;
        rst_n = 1'b0; scb_base = 32'h0100; stall = 1'b0;
        rx_valid = 0; rx_last = 0; rx_group = 0; rx_data = 0; ru_resume = 0;
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R13 reset state
        chk(busy == 0, "R13", "busy in reset", busy, 0);
        chk(irq == 0, "R13", "irq in reset", irq, 0);
        chk(mem_req == 0, "R13", "mem_req in reset", mem_req, 0);
        chk(ru_suspended == 0, "R13", "suspended in reset", ru_suspended, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R2..R9, R11
        for (int v = 0; v < NV; v++) begin
            caps[0] = VEC[v].c0; caps[1] = VEC[v].c1; caps[2] = VEC[v].c2; caps[3] = VEC[v].c3;
            lastm = VEC[v].last; stall = VEC[v].stl;
            setup(16'h0008);
            b0 = irq_cnt; o0 = ovr_cnt; r0 = rnr_cnt;
            send(VEC[v].seed, VEC[v].len, VEC[v].grp);
            wait_done(b0);
            check_frame(VEC[v].seed, VEC[v].len, VEC[v].grp, o0, r0, 1'b0);
            repeat (3) @(negedge clk);
        end

        // R1: a frame arriving during a walk is discarded whole
        caps[0] = 200; caps[1] = 10; caps[2] = 10; caps[3] = 10; lastm = 4'b1000; stall = 1'b1;
        setup(16'h0008);
        b0 = irq_cnt; o0 = ovr_cnt; r0 = rnr_cnt;
        send(9, 80, 1'b0);
        send(10, 80, 1'b0);
        wait_done(b0);
        q0 = req_cnt;
        repeat (300) @(negedge clk);
        chk(irq_cnt == b0 + 1, "R1", "no irq for frame sent while busy", irq_cnt - b0, 1);
        chk(req_cnt == q0, "R1", "no memory request after drop", req_cnt - q0, 0);
        check_frame(9, 80, 1'b0, o0, r0, 1'b0);

        // R10: park, drop while parked, resume
        stall = 1'b0;
        setup(16'h4008);
        b0 = irq_cnt; o0 = ovr_cnt; r0 = rnr_cnt;
        send(11, 64, 1'b1);
        wait_done(b0);
        check_frame(11, 64, 1'b1, o0, r0, 1'b1);
        chk(ru_suspended == 1, "R10", "suspended after park", ru_suspended, 1);
        setup(16'h0008);
        b0 = irq_cnt; q0 = req_cnt;
        send(12, 64, 1'b0);
        repeat (300) @(negedge clk);
        chk(irq_cnt == b0, "R10", "no irq while suspended", irq_cnt - b0, 0);
        chk(req_cnt == q0, "R10", "no memory request while suspended", req_cnt - q0, 0);
        chk(rd16(FD0) == 16'h0, "R10", "status untouched while suspended", rd16(FD0), 0);
        chk(ru_suspended == 1, "R10", "still suspended", ru_suspended, 1);
        ru_resume = 1'b1;
        @(negedge clk);
        ru_resume = 1'b0;
        chk(ru_suspended == 0, "R10", "resume clears suspended", ru_suspended, 0);
        b0 = irq_cnt; o0 = ovr_cnt; r0 = rnr_cnt;
        send(13, 90, 1'b0);
        wait_done(b0);
        check_frame(13, 90, 1'b0, o0, r0, 1'b0);

        finish_run();
    end
endmodule